// File: doc/BRIEF.md
# Dispatch Resource Checker

This block sits between the bottom of an instruction queue and the execution units. In each cycle it looks at the two oldest queue entries, called candidates 0 and 1, and decides which of them may dispatch. It makes the decision combinationally from the current resource state. It then records the resources taken by the granted instructions at the clock edge.

Each candidate is tested against the same gates, in this order:

- **Branch readiness.** A branch must already have executed.
- **Rename space.** There must be enough free rename tags in the candidate's pool. The integer pool and the floating-point pool are separate.
- **Station room.** The target execution unit must have a free reservation station.
- **Completion-queue space.** There must be a free completion-queue entry.

Candidate 1 is granted only behind candidate 0. When it is tested, it is charged for everything candidate 0 has already claimed in the same cycle.

A dispatched branch is one the branch unit did not fold, so it was not taken. It uses no completion-queue entry, no station and no rename tag. Rename tags come back to their pool through two release ports, driven by writeback.

Top module: `dispatch_resource_checker`

## Requirements
- R1: Only the two candidates are considered each cycle. An invalid candidate is never granted. Candidate 1 (grant bit 1) is granted only in a cycle where candidate 0 (grant bit 0) is also granted.
- R2: There are two separate rename pools, integer (pool select 0) and floating-point (pool select 1), each with six tags numbered 0 to 5. All tags are free after reset. A release into one pool never frees a tag of the other.
- R3: A non-branch candidate needs as many free tags of its pool as its destination count (0, 1 or 2) and is denied otherwise. When both candidates use the same pool, their counts are added before candidate 1 is granted.
- R4: A non-branch candidate needs one free station on its unit. The room of unit u is the 2-bit field at bits [2u+1:2u] of `stn_room`. Two candidates aimed at the same unit need a room of at least 2.
- R5: Each dispatched non-branch instruction takes one completion-queue entry, which must be covered by `cq_free`. `cq_alloc` reports the number taken in the cycle.
- R6: A branch candidate is granted only if its executed flag is set. Once granted, it takes no completion-queue entry, no station and no rename tag, and its unit and destination count are ignored.
- R7: Tags are handed out lowest-numbered free first, candidate 0 before candidate 1. A candidate's first destination tag is in bits [2:0] of its tag output and its second in bits [5:3]. Fields of absent destinations, and of ungranted candidates, read 0.
- R8: A granted tag stays busy until it is released. A tag released in a cycle becomes grantable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| c0_valid | input | 1 | Candidate 0 present |
| c0_unit | input | 2 | Candidate 0 target unit |
| c0_fp | input | 1 | Candidate 0 pool select (1 = floating point) |
| c0_ndst | input | 2 | Candidate 0 renamed destination count |
| c0_branch | input | 1 | Candidate 0 is a branch |
| c0_executed | input | 1 | Candidate 0 branch has executed |
| c1_valid | input | 1 | Candidate 1 present |
| c1_unit | input | 2 | Candidate 1 target unit |
| c1_fp | input | 1 | Candidate 1 pool select |
| c1_ndst | input | 2 | Candidate 1 renamed destination count |
| c1_branch | input | 1 | Candidate 1 is a branch |
| c1_executed | input | 1 | Candidate 1 branch has executed |
| stn_room | input | 8 | Free station count per unit, 2 bits each |
| cq_free | input | 3 | Free completion-queue entries (0 to 6) |
| rel_valid | input | 2 | Release port valid bits |
| rel_fp | input | 2 | Release port pool selects |
| rel_tag | input | 6 | Release port tags, port 0 in [2:0] |
| grant | output | 2 | Dispatch grant per candidate |
| cq_alloc | output | 2 | Completion-queue entries taken this cycle |
| tag_c0 | output | 6 | Candidate 0 allocated tags |
| tag_c1 | output | 6 | Candidate 1 allocated tags |

## Verification
Suppose a pool's free mask is corrupted, for example a tag left busy after its release or a tag freed twice. The fault shows at the ports in the first cycle that draws on that pool: either a tag number differs from the lowest free one, or a grant appears where the pool should be exhausted, or the reverse. A faulty charge of candidate 0's claims against candidate 1 shows in the same cycle as a wrong value of grant bit 1. The stimulus therefore drains each pool to empty, releases tags out of order and draws them again, so that every error in the mask surfaces within one or two cycles.

// File: rtl/drc_pkg.sv
package drc_pkg;

    typedef enum logic {
        POOL_INT = 1'b0,
        POOL_FP  = 1'b1
    } pool_e;

    localparam int NUM_POOLS = 2;
    localparam int NUM_CAND  = 2;
    localparam int MAX_DST   = 2;

endpackage

// File: rtl/drc_rename_pool.sv
module drc_rename_pool #(
    parameter int DEPTH = 6,
    parameter int TAG_W = 3,
    parameter int CNT_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           take0,
    input  logic [1:0]           take1,
    input  logic [1:0]           rel_vld,
    input  logic [2*TAG_W-1:0]   rel_tag,
    output logic [CNT_W-1:0]     free_cnt,
    output logic [2*TAG_W-1:0]   tags0,
    output logic [2*TAG_W-1:0]   tags1
);
    localparam int PICKS = 4;

    logic [DEPTH-1:0] free_q;
    logic [DEPTH-1:0] alloc_m;
    logic [DEPTH-1:0] rel_m;
    logic [TAG_W-1:0] pick [PICKS];
    logic [PICKS-1:0] pick_ok;
    logic [1:0]       base1;

    // lowest-numbered free tags, in ascending order
    always_comb begin
        int k;
        k = 0;
        for (int j = 0; j < PICKS; j++) begin
            pick[j] = '0;
        end
        pick_ok = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (free_q[i] && k < PICKS) begin
                pick[k]    = TAG_W'(i);
                pick_ok[k] = 1'b1;
                k          = k + 1;
            end
        end
    end

    always_comb begin
        base1 = take0 + 2'd1;
        tags0 = '0;
        tags1 = '0;
        if (take0 != 2'd0) tags0[TAG_W-1:0]       = pick[0];
        if (take0 == 2'd2) tags0[2*TAG_W-1:TAG_W] = pick[1];
        if (take1 != 2'd0) tags1[TAG_W-1:0]       = pick[take0];
        if (take1 == 2'd2) tags1[2*TAG_W-1:TAG_W] = pick[base1];
    end

    always_comb begin
        int total;
        total   = int'(take0) + int'(take1);
        alloc_m = '0;
        for (int j = 0; j < PICKS; j++) begin
            if (j < total && pick_ok[j]) alloc_m[pick[j]] = 1'b1;
        end
        rel_m = '0;
        for (int r = 0; r < 2; r++) begin
            if (rel_vld[r] && int'(rel_tag[r*TAG_W +: TAG_W]) < DEPTH) begin
                rel_m[rel_tag[r*TAG_W +: TAG_W]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) free_q <= '1;
        else        free_q <= (free_q & ~alloc_m) | rel_m;
    end

    assign free_cnt = CNT_W'($countones(free_q));

endmodule

// File: rtl/drc_grant_logic.sv
module drc_grant_logic #(
    parameter int NUM_UNITS = 4,
    parameter int STN_W     = 2,
    parameter int CQ_W      = 3,
    parameter int CNT_W     = 3,
    parameter int UNIT_W    = 2
) (
    input  logic [1:0]                   v,
    input  logic [1:0][UNIT_W-1:0]       unit,
    input  logic [1:0]                   fp,
    input  logic [1:0][1:0]              ndst,
    input  logic [1:0]                   br,
    input  logic [1:0]                   ex,
    input  logic [NUM_UNITS*STN_W-1:0]   stn_room,
    input  logic [CQ_W-1:0]              cq_free,
    input  logic [CNT_W-1:0]             int_free,
    input  logic [CNT_W-1:0]             fp_free,
    output logic [1:0]                   grant,
    output logic [1:0]                   int_take0,
    output logic [1:0]                   int_take1,
    output logic [1:0]                   fp_take0,
    output logic [1:0]                   fp_take1,
    output logic [1:0]                   cq_take
);
    logic [STN_W-1:0] room0, room1;
    logic [CNT_W-1:0] pool0, pool1;
    logic             claims0;

    always_comb begin
        room0 = stn_room[unit[0]*STN_W +: STN_W];
        room1 = stn_room[unit[1]*STN_W +: STN_W];
        pool0 = fp[0] ? fp_free : int_free;
        pool1 = fp[1] ? fp_free : int_free;
    end

    // candidate 0: branch gate, then rename, station, completion queue
    always_comb begin
        if (!v[0])      grant[0] = 1'b0;
        else if (br[0]) grant[0] = ex[0];
        else            grant[0] = (int'(pool0) >= int'(ndst[0])) &&
                                   (int'(room0) >= 1) &&
                                   (int'(cq_free) >= 1);
    end

    // candidate 1 is charged for whatever candidate 0 claims
    always_comb begin
        int need_pool, need_room, need_cq;
        claims0   = grant[0] && !br[0];
        need_pool = int'(ndst[1]) +
                    ((claims0 && fp[0] == fp[1]) ? int'(ndst[0]) : 0);
        need_room = 1 + ((claims0 && unit[0] == unit[1]) ? 1 : 0);
        need_cq   = 1 + (claims0 ? 1 : 0);
        if (!grant[0] || !v[1]) grant[1] = 1'b0;
        else if (br[1])         grant[1] = ex[1];
        else                    grant[1] = (int'(pool1) >= need_pool) &&
                                           (int'(room1) >= need_room) &&
                                           (int'(cq_free) >= need_cq);
    end

    always_comb begin
        int_take0 = (claims0 && !fp[0]) ? ndst[0] : 2'd0;
        fp_take0  = (claims0 &&  fp[0]) ? ndst[0] : 2'd0;
        int_take1 = (grant[1] && !br[1] && !fp[1]) ? ndst[1] : 2'd0;
        fp_take1  = (grant[1] && !br[1] &&  fp[1]) ? ndst[1] : 2'd0;
        cq_take   = {1'b0, claims0} + {1'b0, grant[1] && !br[1]};
    end

endmodule

// File: rtl/dispatch_resource_checker.sv
module dispatch_resource_checker #(
    parameter  int NUM_UNITS = 4,
    parameter  int STN_W     = 2,
    parameter  int INT_REGS  = 6,
    parameter  int FP_REGS   = 6,
    parameter  int CQ_DEPTH  = 6,
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
    localparam int MAX_REGS  = (INT_REGS > FP_REGS) ? INT_REGS : FP_REGS,
    localparam int TAG_W     = $clog2(MAX_REGS),
    localparam int CNT_W     = $clog2(MAX_REGS + 1),
    localparam int CQ_W      = $clog2(CQ_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       c0_valid,
    input  logic [UNIT_W-1:0]          c0_unit,
    input  logic                       c0_fp,
    input  logic [1:0]                 c0_ndst,
    input  logic                       c0_branch,
    input  logic                       c0_executed,
    input  logic                       c1_valid,
    input  logic [UNIT_W-1:0]          c1_unit,
    input  logic                       c1_fp,
    input  logic [1:0]                 c1_ndst,
    input  logic                       c1_branch,
    input  logic                       c1_executed,
    input  logic [NUM_UNITS*STN_W-1:0] stn_room,
    input  logic [CQ_W-1:0]            cq_free,
    input  logic [1:0]                 rel_valid,
    input  logic [1:0]                 rel_fp,
    input  logic [2*TAG_W-1:0]         rel_tag,
    output logic [1:0]                 grant,
    output logic [1:0]                 cq_alloc,
    output logic [2*TAG_W-1:0]         tag_c0,
    output logic [2*TAG_W-1:0]         tag_c1
);
    import drc_pkg::*;

    logic [1:0]         take0_p   [NUM_POOLS];
    logic [1:0]         take1_p   [NUM_POOLS];
    logic [1:0]         rel_vld_p [NUM_POOLS];
    logic [CNT_W-1:0]   free_p    [NUM_POOLS];
    logic [2*TAG_W-1:0] tags0_p   [NUM_POOLS];
    logic [2*TAG_W-1:0] tags1_p   [NUM_POOLS];

    drc_grant_logic #(
        .NUM_UNITS(NUM_UNITS), .STN_W(STN_W), .CQ_W(CQ_W),
        .CNT_W(CNT_W), .UNIT_W(UNIT_W)
    ) u_grant (
        .v        ({c1_valid, c0_valid}),
        .unit     ({c1_unit, c0_unit}),
        .fp       ({c1_fp, c0_fp}),
        .ndst     ({c1_ndst, c0_ndst}),
        .br       ({c1_branch, c0_branch}),
        .ex       ({c1_executed, c0_executed}),
        .stn_room (stn_room),
        .cq_free  (cq_free),
        .int_free (free_p[POOL_INT]),
        .fp_free  (free_p[POOL_FP]),
        .grant    (grant),
        .int_take0(take0_p[POOL_INT]),
        .int_take1(take1_p[POOL_INT]),
        .fp_take0 (take0_p[POOL_FP]),
        .fp_take1 (take1_p[POOL_FP]),
        .cq_take  (cq_alloc)
    );

    // a release port reaches only the pool its select names
    always_comb begin
        for (int g = 0; g < NUM_POOLS; g++) begin
            for (int r = 0; r < 2; r++) begin
                rel_vld_p[g][r] = rel_valid[r] && (int'(rel_fp[r]) == g);
            end
        end
    end

    for (genvar g = 0; g < NUM_POOLS; g++) begin : g_pool
        localparam int DEPTH = (g == int'(POOL_FP)) ? FP_REGS : INT_REGS;
        drc_rename_pool #(
            .DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)
        ) u_pool (
            .clk     (clk),
            .rst_n   (rst_n),
            .take0   (take0_p[g]),
            .take1   (take1_p[g]),
            .rel_vld (rel_vld_p[g]),
            .rel_tag (rel_tag),
            .free_cnt(free_p[g]),
            .tags0   (tags0_p[g]),
            .tags1   (tags1_p[g])
        );
    end

    assign tag_c0 = c0_fp ? tags0_p[POOL_FP] : tags0_p[POOL_INT];
    assign tag_c1 = c1_fp ? tags1_p[POOL_FP] : tags1_p[POOL_INT];

endmodule

// File: rtl/drc_checker.sv
module drc_checker #(
    parameter int NUM_UNITS = 4,
    parameter int STN_W     = 2,
    parameter int UNIT_W    = 2,
    parameter int TAG_W     = 3,
    parameter int CQ_W      = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       c0_valid,
    input logic [UNIT_W-1:0]          c0_unit,
    input logic                       c0_fp,
    input logic [1:0]                 c0_ndst,
    input logic                       c0_branch,
    input logic                       c0_executed,
    input logic                       c1_valid,
    input logic                       c1_fp,
    input logic [1:0]                 c1_ndst,
    input logic                       c1_branch,
    input logic [NUM_UNITS*STN_W-1:0] stn_room,
    input logic [CQ_W-1:0]            cq_free,
    input logic [1:0]                 grant,
    input logic [1:0]                 cq_alloc,
    input logic [2*TAG_W-1:0]         tag_c0,
    input logic [2*TAG_W-1:0]         tag_c1
);
    assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> grant[0]);

    assert_valid_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] |-> c0_valid) and (grant[1] |-> c1_valid));

    assert_two_dst_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !c0_branch && c0_ndst == 2'd2)
        |-> tag_c0[TAG_W-1:0] != tag_c0[2*TAG_W-1:TAG_W]);

    assert_station_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !c0_branch) |-> stn_room[c0_unit*STN_W +: STN_W] != '0);

    assert_cq_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cq_alloc) <= int'(cq_free));

    assert_branch_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_valid && c0_branch && !c0_executed) |-> !grant[0]);

    assert_no_shared_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b11 && !c0_branch && !c1_branch && c0_fp == c1_fp &&
         c0_ndst != 2'd0 && c1_ndst != 2'd0)
        |-> tag_c0[TAG_W-1:0] != tag_c1[TAG_W-1:0]);

endmodule

bind dispatch_resource_checker drc_checker #(
    .NUM_UNITS(NUM_UNITS), .STN_W(STN_W), .UNIT_W(UNIT_W),
    .TAG_W(TAG_W), .CQ_W(CQ_W)
) u_drc_checker (
    .clk(clk), .rst_n(rst_n),
    .c0_valid(c0_valid), .c0_unit(c0_unit), .c0_fp(c0_fp),
    .c0_ndst(c0_ndst), .c0_branch(c0_branch), .c0_executed(c0_executed),
    .c1_valid(c1_valid), .c1_fp(c1_fp), .c1_ndst(c1_ndst),
    .c1_branch(c1_branch), .stn_room(stn_room), .cq_free(cq_free),
    .grant(grant), .cq_alloc(cq_alloc), .tag_c0(tag_c0), .tag_c1(tag_c1)
);

// File: tb/tb_dispatch_resource_checker.sv
module tb_dispatch_resource_checker;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic       v0;
        logic [1:0] u0;
        logic       fp0;
        logic [1:0] n0;
        logic       br0;
        logic       ex0;
        logic       v1;
        logic [1:0] u1;
        logic       fp1;
        logic [1:0] n1;
        logic       br1;
        logic       ex1;
        logic [7:0] room;
        logic [2:0] cq;
        logic [1:0] eg;
        logic [1:0] ecq;
        logic [5:0] et0;
        logic [5:0] et1;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1,0,0,1,0,0, 1,1,0,1,0,0, 8'h55,6, 2'b11,2, 6'o00,6'o01, 7}, // R7 int 0,1
        '{1,0,0,2,0,0, 1,2,1,2,0,0, 8'h55,6, 2'b11,2, 6'o32,6'o10, 3}, // R3 two pools
        '{1,1,0,2,0,0, 1,1,0,1,0,0, 8'h55,6, 2'b01,1, 6'o54,6'o00, 3}, // R3 pool summed
        '{1,0,0,1,0,0, 1,2,1,1,0,0, 8'h55,6, 2'b00,0, 6'o00,6'o00, 3}, // R3 int empty
        '{1,3,1,0,0,0, 1,3,1,0,0,0, 8'h55,6, 2'b01,1, 6'o00,6'o00, 4}, // R4 same unit room 1
        '{1,3,1,0,0,0, 1,3,1,0,0,0, 8'h95,6, 2'b11,2, 6'o00,6'o00, 4}, // R4 room 2
        '{1,0,1,0,0,0, 1,1,1,0,0,0, 8'h55,1, 2'b01,1, 6'o00,6'o00, 5}, // R5 one entry
        '{1,0,1,0,0,0, 1,1,1,0,0,0, 8'h55,0, 2'b00,0, 6'o00,6'o00, 5}, // R5 none
        '{1,0,0,0,1,0, 1,0,1,0,0,0, 8'h55,6, 2'b00,0, 6'o00,6'o00, 6}, // R6 unexecuted
        '{1,0,0,0,1,1, 1,0,1,0,0,0, 8'h55,1, 2'b11,1, 6'o00,6'o00, 6}, // R6 no CQ slot
        '{1,2,0,2,1,1, 0,0,0,0,0,0, 8'h00,0, 2'b01,0, 6'o00,6'o00, 6}, // R6 ignores room
        '{0,0,0,0,0,0, 1,0,1,0,0,0, 8'h55,6, 2'b00,0, 6'o00,6'o00, 1}, // R1 order
        '{1,2,1,2,0,0, 1,2,1,2,0,0, 8'h65,6, 2'b11,2, 6'o32,6'o54, 3}, // R3 fp drain
        '{1,0,1,1,0,0, 0,0,0,0,0,0, 8'h55,6, 2'b00,0, 6'o00,6'o00, 3}  // R3 fp empty
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       c0_valid, c0_fp, c0_branch, c0_executed;
    logic       c1_valid, c1_fp, c1_branch, c1_executed;
    logic [1:0] c0_unit, c0_ndst, c1_unit, c1_ndst;
    logic [7:0] stn_room;
    logic [2:0] cq_free;
    logic [1:0] rel_valid, rel_fp;
    logic [5:0] rel_tag;
    logic [1:0] grant, cq_alloc;
    logic [5:0] tag_c0, tag_c1;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    dispatch_resource_checker dut (
        .clk(clk), .rst_n(rst_n),
        .c0_valid(c0_valid), .c0_unit(c0_unit), .c0_fp(c0_fp),
        .c0_ndst(c0_ndst), .c0_branch(c0_branch), .c0_executed(c0_executed),
        .c1_valid(c1_valid), .c1_unit(c1_unit), .c1_fp(c1_fp),
        .c1_ndst(c1_ndst), .c1_branch(c1_branch), .c1_executed(c1_executed),
        .stn_room(stn_room), .cq_free(cq_free),
        .rel_valid(rel_valid), .rel_fp(rel_fp), .rel_tag(rel_tag),
        .grant(grant), .cq_alloc(cq_alloc), .tag_c0(tag_c0), .tag_c1(tag_c1)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input string req,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        c0_valid = 0; c0_unit = 0; c0_fp = 0; c0_ndst = 0; c0_branch = 0; c0_executed = 0;
        c1_valid = 0; c1_unit = 0; c1_fp = 0; c1_ndst = 0; c1_branch = 0; c1_executed = 0;
        stn_room = 8'h55; cq_free = 3'd6; rel_valid = 0; rel_fp = 0; rel_tag = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();

        // R1: idle inputs after reset give no grant, no CQ use, zero tags
        #1;
        check("reset grant", "R1", 32'(grant), 0);
        check("reset cq_alloc", "R5", 32'(cq_alloc), 0);
        check("reset tags", "R7", 32'({tag_c0, tag_c1}), 0);

        for (int i = 0; i < NVEC; i++) begin
            string rq;
            @(negedge clk);
            rq = $sformatf("R%0d", VEC[i].req);
            c0_valid = VEC[i].v0; c0_unit = VEC[i].u0; c0_fp = VEC[i].fp0;
            c0_ndst = VEC[i].n0; c0_branch = VEC[i].br0; c0_executed = VEC[i].ex0;
            c1_valid = VEC[i].v1; c1_unit = VEC[i].u1; c1_fp = VEC[i].fp1;
            c1_ndst = VEC[i].n1; c1_branch = VEC[i].br1; c1_executed = VEC[i].ex1;
            stn_room = VEC[i].room; cq_free = VEC[i].cq;
            #1;
            check($sformatf("row %0d grant", i), rq, 32'(grant), 32'(VEC[i].eg));
            check($sformatf("row %0d cq_alloc", i), rq, 32'(cq_alloc), 32'(VEC[i].ecq));
            check($sformatf("row %0d tag_c0", i), "R7", 32'(tag_c0), 32'(VEC[i].et0));
            check($sformatf("row %0d tag_c1", i), "R7", 32'(tag_c1), 32'(VEC[i].et1));
        end

        // R8: both pools are empty; release int tags 1 and 4, not visible yet
        @(negedge clk);
        idle();
        rel_valid = 2'b11; rel_fp = 2'b00; rel_tag = {3'd4, 3'd1};
        c0_valid = 1; c0_ndst = 2'd1;
        #1;
        check("release same cycle", "R8", 32'(grant), 0);

        // R8: released tags granted from the next cycle, lowest first (R7)
        @(negedge clk);
        idle();
        c0_valid = 1; c0_ndst = 2'd2;
        #1;
        check("reuse grant", "R8", 32'(grant), 1);
        check("reuse tags", "R7", 32'(tag_c0), 32'(6'o41));

        // R8: granted tags stay busy
        @(negedge clk);
        idle();
        c0_valid = 1; c0_ndst = 2'd1;
        #1;
        check("busy after grant", "R8", 32'(grant), 0);

        // R2: an fp release does not feed the int pool
        @(negedge clk);
        idle();
        rel_valid = 2'b10; rel_fp = 2'b10; rel_tag = {3'd3, 3'd0};
        @(negedge clk);
        idle();
        c0_valid = 1; c0_ndst = 2'd1;
        #1;
        check("int after fp release", "R2", 32'(grant), 0);
        @(negedge clk);
        idle();
        c0_valid = 1; c0_fp = 1; c0_ndst = 2'd1;
        #1;
        check("fp reuse grant", "R2", 32'(grant), 1);
        check("fp reuse tag", "R7", 32'(tag_c0), 32'(6'o03));

        // R2: reset frees every tag of both pools
        do_reset();
        @(negedge clk);
        idle();
        c0_valid = 1; c0_ndst = 2'd2; c1_valid = 1; c1_unit = 2'd1; c1_ndst = 2'd2;
        #1;
        check("post reset grant", "R2", 32'(grant), 3);
        check("post reset c0 tags", "R2", 32'(tag_c0), 32'(6'o10));
        check("post reset c1 tags", "R2", 32'(tag_c1), 32'(6'o32));
        @(negedge clk);
        idle();
        c0_valid = 1; c0_fp = 1; c0_ndst = 2'd2;
        #1;
        check("post reset fp tags", "R2", 32'(tag_c0), 32'(6'o10));

        @(negedge clk);
        idle();
        finish_run();
    end

endmodule